// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Early Branch Resolver

This block is the decode-stage control slice of a five-stage in-order pipeline. It owns the fetch program counter, the fetch-to-decode register and the control half of the decode-to-execute register. Each cycle it decodes the instruction held in decode and checks it against the instruction one stage ahead. If that older instruction is a load whose destination register is one of the two sources of the decoding instruction, the result cannot arrive in time. The block then freezes fetch and decode for one cycle and sends an empty slot into execute.

The same stage also resolves compare-equal branches. The register file supplies the two source values for the decoding instruction. The block marks them equal when the bitwise XOR of the two values reduces to zero. Fetch always goes on sequentially, so a branch is assumed not taken. When the branch turns out taken, the one wrongly fetched instruction is cleared to all zeros, which acts as a no-op. The program counter is then loaded with the branch target: the branch's own address plus four, plus the sign-extended 16-bit offset shifted left by two. A taken branch therefore costs one cycle. A load-use stall takes precedence over a branch decision in the same cycle.

Top module: `id_hazard_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes RESET_PC (default 0), `ifid_instr`, `ifid_pc` and `ex_ctrl` become zero.
- R2: With neither `stall` nor `flush` high, the next edge loads `pc` with `pc`+4 and loads `ifid_instr`/`ifid_pc` with `fetch_instr` and the old `pc`.
- R3: `stall` is high in the same cycle exactly when `ex_ctrl[4]` (load) is set and `ex_rt` equals `rs_idx` or `rt_idx`. These are instruction bits [25:21] and [20:16] of `ifid_instr`. The zero register index is not excluded.
- R4: While `stall` is high, `pc_write` and `ifid_write` are low, and the next edge leaves `pc`, `ifid_instr` and `ifid_pc` unchanged. Otherwise both write enables are high.
- R5: An edge taken while `stall` is high loads `ex_ctrl` with all zeros.
- R6: `flush` is high exactly when `stall` is low, the opcode `ifid_instr[31:26]` is 6'h04 (branch-if-equal), and `rs_val` equals `rt_val` bit for bit.
- R7: An edge taken while `flush` is high loads `pc` with `ifid_pc`+4+(sign-extended `ifid_instr[15:0]` shifted left by 2) and loads `ifid_instr` and `ifid_pc` with zero.
- R8: A branch-if-equal whose operands differ raises no `flush`, and fetch continues at `pc`+4.
- R9: When `stall` and a branch-if-equal with equal operands coincide, `flush` stays low and `pc` holds.
- R10: Without a stall, the next edge loads `ex_ctrl` = {reg_write, mem_read, mem_write, mem_to_reg, alu_src, reg_dst} decoded from the opcode: 6'h00 gives 6'b100001, 6'h23 (load) gives 6'b110110, 6'h2B (store) gives 6'b001010, and every other opcode, including 6'h04, gives 6'b000000.
- R11: Every edge loads `ex_rs`, `ex_rt` and `ex_rd` with bits [25:21], [20:16] and [15:11] of `ifid_instr`, stall or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction read at `pc` |
| rs_val | input | XLEN | Register file value for `rs_idx` |
| rt_val | input | XLEN | Register file value for `rt_idx` |
| pc | output | XLEN | Fetch program counter |
| ifid_instr | output | 32 | Instruction held in decode |
| ifid_pc | output | XLEN | Address of the instruction in decode |
| rs_idx | output | 5 | First source index of the decode instruction |
| rt_idx | output | 5 | Second source index of the decode instruction |
| ex_ctrl | output | 6 | Control bits latched into execute |
| ex_rs | output | 5 | First source index latched into execute |
| ex_rt | output | 5 | Second source index latched into execute |
| ex_rd | output | 5 | Destination field latched into execute |
| stall | output | 1 | Load-use bubble this cycle |
| flush | output | 1 | Taken branch: clear decode and redirect |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Decode register update enable |

## Verification
`stall`, `flush`, `pc_write`, `ifid_write` and the source indices are combinational, so they are due in the same cycle the inputs are applied. The bench drives inputs at the falling edge and samples these outputs 1 ns later. `pc`, the decode register and the execute fields are due one edge later. The bench therefore samples them at the next falling edge and compares them with a reference model that is advanced once per step. When the model predicts a stall, a taken branch, a not-taken branch or a stall-versus-branch collision, the bench adds checks for that case at exactly that later sample point.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int IDX_W   = 5;
    localparam int IMM_W   = 16;

    localparam logic [OP_W-1:0] OP_ALU   = 6'h00;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OP_BREQ  = 6'h04;

    // Control bundle carried into execute; field order fixes the bit layout.
    typedef struct packed {
        logic reg_write;
        logic mem_read;
        logic mem_write;
        logic mem_to_reg;
        logic alu_src;
        logic reg_dst;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic [63:0]        pc;
    } ifid_wide_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [IDX_W-1:0] rs;
        logic [IDX_W-1:0] rt;
        logic [IDX_W-1:0] rd;
    } idex_t;

    function automatic ctrl_t ctrl_of(input logic [OP_W-1:0] op);
        ctrl_t c;
        c = '0;
        unique case (op)
            OP_ALU: begin
                c.reg_write = 1'b1;
                c.reg_dst   = 1'b1;
            end
            OP_LOAD: begin
                c.reg_write  = 1'b1;
                c.mem_read   = 1'b1;
                c.mem_to_reg = 1'b1;
                c.alu_src    = 1'b1;
            end
            OP_STORE: begin
                c.mem_write = 1'b1;
                c.alu_src   = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [OP_W-1:0] op_field(input logic [INSTR_W-1:0] i);
        return i[31:26];
    endfunction

    function automatic logic [IDX_W-1:0] rs_field(input logic [INSTR_W-1:0] i);
        return i[25:21];
    endfunction

    function automatic logic [IDX_W-1:0] rt_field(input logic [INSTR_W-1:0] i);
        return i[20:16];
    endfunction

    function automatic logic [IDX_W-1:0] rd_field(input logic [INSTR_W-1:0] i);
        return i[15:11];
    endfunction

    function automatic logic [IMM_W-1:0] imm_field(input logic [INSTR_W-1:0] i);
        return i[15:0];
    endfunction

endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
    import hzd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [IDX_W-1:0]   rs,
    output logic [IDX_W-1:0]   rt,
    output logic [IDX_W-1:0]   rd,
    output logic [IMM_W-1:0]   imm,
    output ctrl_t              ctrl,
    output logic               is_breq
);

    logic [OP_W-1:0] op;

    always_comb begin
        op      = op_field(instr);
        rs      = rs_field(instr);
        rt      = rt_field(instr);
        rd      = rd_field(instr);
        imm     = imm_field(instr);
        ctrl    = ctrl_of(op);
        is_breq = (op == OP_BREQ);
    end

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
    import hzd_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic                        ex_mem_read,
    input  logic [IDX_W-1:0]            ex_dst,
    input  logic [N_SRC-1:0][IDX_W-1:0] id_src,
    output logic                        stall
);

    logic [N_SRC-1:0] hit;

    // One comparator per decode-stage source operand.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = (id_src[g] == ex_dst);
    end

    assign stall = ex_mem_read && (|hit);

endmodule

// File: rtl/hzd_branch_eq.sv
module hzd_branch_eq
    import hzd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic             is_breq,
    input  logic             hold,
    input  logic [XLEN-1:0]  br_pc,
    input  logic [IMM_W-1:0] offset,
    output logic             taken,
    output logic [XLEN-1:0]  target
);

    localparam int EXT_W = XLEN - IMM_W - 2;

    logic [XLEN-1:0] diff;
    logic [XLEN-1:0] disp;

    // Per-bit difference; equality is the NOR of all difference bits.
    for (genvar b = 0; b < XLEN; b++) begin : g_xor
        assign diff[b] = opa[b] ^ opb[b];
    end

    assign disp   = {{EXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    assign target = br_pc + XLEN'(4) + disp;
    assign taken  = is_breq && !hold && !(|diff);

endmodule

// File: rtl/id_hazard_branch_unit.sv
module id_hazard_branch_unit
    import hzd_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        fetch_instr,
    input  logic [XLEN-1:0]    rs_val,
    input  logic [XLEN-1:0]    rt_val,
    output logic [XLEN-1:0]    pc,
    output logic [31:0]        ifid_instr,
    output logic [XLEN-1:0]    ifid_pc,
    output logic [4:0]         rs_idx,
    output logic [4:0]         rt_idx,
    output logic [5:0]         ex_ctrl,
    output logic [4:0]         ex_rs,
    output logic [4:0]         ex_rt,
    output logic [4:0]         ex_rd,
    output logic               stall,
    output logic               flush,
    output logic               pc_write,
    output logic               ifid_write
);

    logic [XLEN-1:0]    pc_q, pc_d;
    logic [INSTR_W-1:0] if_instr_q, if_instr_d;
    logic [XLEN-1:0]    if_pc_q, if_pc_d;
    idex_t              ex_q, ex_d;

    logic [IDX_W-1:0]   d_rs, d_rt, d_rd;
    logic [IMM_W-1:0]   d_imm;
    ctrl_t              d_ctrl;
    logic               d_breq;
    logic               hz;
    logic               br_taken;
    logic [XLEN-1:0]    br_target;
    ctrl_t              ex_ctrl_s;

    hzd_decode u_dec (
        .instr   (if_instr_q),
        .rs      (d_rs),
        .rt      (d_rt),
        .rd      (d_rd),
        .imm     (d_imm),
        .ctrl    (d_ctrl),
        .is_breq (d_breq)
    );

    assign ex_ctrl_s = ex_q.ctrl;

    hzd_load_use #(.N_SRC(2)) u_lu (
        .ex_mem_read (ex_ctrl_s.mem_read),
        .ex_dst      (ex_q.rt),
        .id_src      ({d_rs, d_rt}),
        .stall       (hz)
    );

    hzd_branch_eq #(.XLEN(XLEN)) u_br (
        .opa     (rs_val),
        .opb     (rt_val),
        .is_breq (d_breq),
        .hold    (hz),
        .br_pc   (if_pc_q),
        .offset  (d_imm),
        .taken   (br_taken),
        .target  (br_target)
    );

    always_comb begin
        pc_d       = pc_q + XLEN'(4);
        if_instr_d = fetch_instr;
        if_pc_d    = pc_q;
        ex_d.ctrl  = d_ctrl;
        ex_d.rs    = d_rs;
        ex_d.rt    = d_rt;
        ex_d.rd    = d_rd;
        if (hz) begin
            pc_d       = pc_q;
            if_instr_d = if_instr_q;
            if_pc_d    = if_pc_q;
            ex_d.ctrl  = '0;
        end else if (br_taken) begin
            pc_d       = br_target;
            if_instr_d = '0;
            if_pc_d    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            if_instr_q <= '0;
            if_pc_q    <= '0;
            ex_q       <= '0;
        end else begin
            pc_q       <= pc_d;
            if_instr_q <= if_instr_d;
            if_pc_q    <= if_pc_d;
            ex_q       <= ex_d;
        end
    end

    assign pc         = pc_q;
    assign ifid_instr = if_instr_q;
    assign ifid_pc    = if_pc_q;
    assign rs_idx     = d_rs;
    assign rt_idx     = d_rt;
    assign ex_ctrl    = ex_q.ctrl;
    assign ex_rs      = ex_q.rs;
    assign ex_rt      = ex_q.rt;
    assign ex_rd      = ex_q.rd;
    assign stall      = hz;
    assign flush      = br_taken;
    assign pc_write   = !hz;
    assign ifid_write = !hz;

endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic            flush,
    input logic [XLEN-1:0] pc,
    input logic [31:0]     ifid_instr,
    input logic [5:0]      ex_ctrl
);

    // R4: the program counter holds across a stall
    a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> pc == $past(pc));

    // R4: the decode register holds across a stall
    a_r4_ifid_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(ifid_instr));

    // R5: a stall sends an empty control slot to execute
    a_r5_bubble: assert property (@(posedge clk) disable iff (rst)
        stall |=> ex_ctrl == 6'b0);

    // R7: a taken branch clears the decode register
    a_r7_flush_zero: assert property (@(posedge clk) disable iff (rst)
        flush |=> ifid_instr == 32'b0);

    // R2: sequential advance when nothing intervenes
    a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (!stall && !flush) |=> pc == $past(pc) + XLEN'(4));

    // R9: stall and flush never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stall && flush));

endmodule

bind id_hazard_branch_unit hzd_checker #(.XLEN(XLEN)) u_hzd_checker (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .flush      (flush),
    .pc         (pc),
    .ifid_instr (ifid_instr),
    .ex_ctrl    (ex_ctrl)
);

// File: tb/tb_id_hazard_branch_unit.sv
`timescale 1ns/1ps
module tb_id_hazard_branch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc, ifid_instr, ifid_pc;
    logic [4:0]  rs_idx, rt_idx, ex_rs, ex_rt, ex_rd;
    logic [5:0]  ex_ctrl;
    logic        stall, flush, pc_write, ifid_write;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    id_hazard_branch_unit dut (
        .clk(clk), .rst(rst), .fetch_instr(fetch_instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
        .ifid_instr(ifid_instr), .ifid_pc(ifid_pc),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .ex_ctrl(ex_ctrl),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
        .stall(stall), .flush(flush), .pc_write(pc_write),
        .ifid_write(ifid_write)
    );

    // reference model state
    logic [31:0] m_pc, m_ins, m_ipc;
    logic [5:0]  m_ctrl;
    logic [4:0]  m_rs, m_rt, m_rd;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_ctrl(input logic [5:0] op);
        if (op == 6'h00) return 6'b100001;
        if (op == 6'h23) return 6'b110110;
        if (op == 6'h2B) return 6'b001010;
        return 6'b000000;
    endfunction

    function automatic logic [31:0] ity(input logic [5:0] op, input int s,
                                        input int t, input logic [15:0] imm);
        return {op, 5'(s), 5'(t), imm};
    endfunction

    function automatic logic [31:0] rty(input int s, input int t, input int d);
        return {6'h00, 5'(s), 5'(t), 5'(d), 11'h0};
    endfunction

    task automatic step(input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b);
        logic [5:0]  op;
        logic [4:0]  s, t;
        logic        hz, is_br, tk;
        logic [31:0] tgt, prev_pc, disp;
        fetch_instr = ins;
        rs_val = a;
        rt_val = b;
        #1;
        op = m_ins[31:26];
        s  = m_ins[25:21];
        t  = m_ins[20:16];
        hz = m_ctrl[4] && (m_rt == s || m_rt == t);
        is_br = (op == 6'h04);
        tk = !hz && is_br && (a == b);
        disp = {{14{m_ins[15]}}, m_ins[15:0], 2'b00};
        tgt = m_ipc + 32'd4 + disp;
        chk("R3", "rs_idx", 32'(rs_idx), 32'(s));
        chk("R3", "rt_idx", 32'(rt_idx), 32'(t));
        chk("R3", "stall", 32'(stall), 32'(hz));
        chk("R6", "flush", 32'(flush), 32'(tk));
        chk("R4", "pc_write", 32'(pc_write), 32'(!hz));
        chk("R4", "ifid_write", 32'(ifid_write), 32'(!hz));
        if (hz && is_br && a == b) chk("R9", "flush under stall", 32'(flush), 32'd0);
        prev_pc = m_pc;
        // advance model
        m_rs = s; m_rt = t; m_rd = m_ins[15:11];
        if (hz) begin
            m_ctrl = 6'b0;
        end else begin
            m_ctrl = exp_ctrl(op);
            if (tk) begin
                m_pc = tgt; m_ins = '0; m_ipc = '0;
            end else begin
                m_ipc = m_pc; m_ins = ins; m_pc = m_pc + 32'd4;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2", "pc", pc, m_pc);
        chk("R2", "ifid_instr", ifid_instr, m_ins);
        chk("R2", "ifid_pc", ifid_pc, m_ipc);
        chk("R10", "ex_ctrl", 32'(ex_ctrl), 32'(m_ctrl));
        chk("R11", "ex_rs", 32'(ex_rs), 32'(m_rs));
        chk("R11", "ex_rt", 32'(ex_rt), 32'(m_rt));
        chk("R11", "ex_rd", 32'(ex_rd), 32'(m_rd));
        if (hz) begin
            chk("R5", "bubble ctrl", 32'(ex_ctrl), 32'd0);
            chk("R4", "pc held", pc, prev_pc);
            if (is_br && a == b) chk("R9", "pc held on branch", pc, prev_pc);
        end
        if (tk) begin
            chk("R7", "branch target", pc, tgt);
            chk("R7", "flushed instr", ifid_instr, 32'd0);
        end
        if (!hz && is_br && a != b) chk("R8", "not-taken pc", pc, prev_pc + 32'd4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset pc", pc, 32'd0);
        chk("R1", "reset ifid_instr", ifid_instr, 32'd0);
        chk("R1", "reset ifid_pc", ifid_pc, 32'd0);
        chk("R1", "reset ex_ctrl", 32'(ex_ctrl), 32'd0);
        rst = 1'b0;
        m_pc = 0; m_ins = 0; m_ipc = 0; m_ctrl = 0; m_rs = 0; m_rt = 0; m_rd = 0;

        // plain ALU, then a load feeding the next instruction's rs
        step(rty(1, 2, 3), 32'd5, 32'd6);
        step(ity(6'h23, 4, 2, 16'h0010), 32'd1, 32'd2);
        step(rty(2, 6, 7), 32'd1, 32'd2);
        step(rty(8, 9, 10), 32'd3, 32'd4);
        step(ity(6'h2B, 2, 3, 16'h0004), 32'd7, 32'd8);
        // load then dependency on rt
        step(ity(6'h23, 1, 9, 16'h0000), 32'd0, 32'd0);
        step(rty(11, 9, 12), 32'd0, 32'd0);
        step(rty(1, 1, 1), 32'd0, 32'd0);
        step(rty(1, 1, 1), 32'd0, 32'd0);
        // branch with equal operands: taken, forward and backward offsets
        step(ity(6'h04, 3, 4, 16'h0003), 32'd0, 32'd0);
        step(rty(1, 2, 3), 32'hA5A5_0001, 32'hA5A5_0001);
        step(ity(6'h04, 5, 6, 16'hFFFE), 32'd0, 32'd0);
        step(rty(1, 2, 3), 32'h0000_00FF, 32'h0000_00FF);
        // branch with unequal operands: not taken
        step(ity(6'h04, 5, 6, 16'h0008), 32'd0, 32'd0);
        step(rty(1, 2, 3), 32'h8000_0000, 32'h0000_0000);
        step(rty(1, 2, 3), 32'd0, 32'd1);
        // load followed by a branch reading the loaded register, equal operands
        step(ity(6'h23, 2, 5, 16'h0000), 32'd0, 32'd0);
        step(ity(6'h04, 5, 7, 16'h0002), 32'd0, 32'd0);
        step(rty(1, 2, 3), 32'd0, 32'd9);
        step(rty(1, 2, 3), 32'd4, 32'd4);
        step(rty(1, 2, 3), 32'd4, 32'd4);

        // mixed traffic on a few registers so hazards recur often
        for (int k = 0; k < 400; k++) begin
            int unsigned r;
            logic [5:0] op;
            logic [31:0] a, b;
            r = $urandom;
            case (r % 5)
                0: op = 6'h00;
                1: op = 6'h23;
                2: op = 6'h2B;
                3: op = 6'h04;
                default: op = 6'h0F;
            endcase
            a = 32'($urandom % 3);
            b = 32'($urandom % 3);
            step({op, 5'((r >> 4) % 4), 5'((r >> 8) % 4), 16'($urandom)}, a, b);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule